// File: doc/BRIEF.md
# Split-Bus Address Tenure Controller

This block handles the address phase of a split-transaction processor bus, from both sides of the bus. On the master side, a request carries an address and transfer attributes. The request is accepted over a valid/ready handshake and held until the bus grant arrives. The block then opens an address tenure: a start strobe lasting one cycle, with the address and attributes driven valid in that same cycle. Address, attributes and the busy indication stay driven and unchanged until an acknowledge closes the tenure. In the cycle after the acknowledge, all drivers are released.

On the observer side, the block watches the shared strobe. The address and attributes are sampled only in a cycle where another master raises the strobe while the bus is marked busy. The captured values are presented as a snoop record, together with a one-cycle valid pulse.

A burst request whose address is not aligned to a double word is refused. The block raises an error pulse for it and never opens a tenure. Back-pressure on the request side is simple. `req_ready` is high only while the master is idle. A request is taken on any rising clock edge where both `req_valid` and `req_ready` are high. The requester must hold its payload stable until that edge.

Top module: `addr_tenure_ctrl`

## Requirements
- R1: After reset, `bus_oe`, `start_out`, `busy_out`, `snp_valid` and `err_out` are 0, and `req_ready` is 1.
- R2: `req_ready` is 1 only while no request is pending or in tenure. It drops in the cycle after a well-formed request is accepted and returns in the cycle after the acknowledge.
- R3: `start_out` never rises before a grant. If `grant_in` is sampled high while a request waits, `start_out` is 1 in the next cycle.
- R4: `start_out` is high for exactly one cycle per tenure.
- R5: From the start cycle until the acknowledge is sampled, `bus_oe` and `busy_out` are 1, and `bus_addr_out`/`bus_attr_out` equal the accepted request and do not change. Attribute layout: bit 4 = burst, bit 3 = write, bits 2:0 = size.
- R6: In the cycle after an acknowledge is sampled during a tenure, `bus_oe` and `busy_out` are both 0.
- R7: An acknowledge sampled in the start-strobe cycle is ignored, so the tenure continues.
- R8: A burst request (attr bit 4 = 1) with address bits 2:0 not all zero makes `err_out` high for exactly the next cycle. No tenure starts, and `req_ready` stays 1.
- R9: When `start_in` and `busy_in` are sampled high together, the next cycle shows `snp_valid` = 1 for one cycle, with `snp_addr`/`snp_attr` holding the sampled bus values.
- R10: Changes on `bus_addr_in`/`bus_attr_in` in cycles without a qualified strobe leave `snp_addr`/`snp_attr` unchanged.
- R11: A `start_in` sampled in the block's own start-strobe cycle is not captured.
- R12: A `start_in` sampled while `busy_in` is 0 is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 32 | Request address |
| req_attr | input | 5 | Request attributes {burst, write, size[2:0]} |
| grant_in | input | 1 | Address bus granted to this master |
| ack_in | input | 1 | Address acknowledge |
| start_out | output | 1 | Start strobe driven by this master |
| busy_out | output | 1 | Address bus busy driven by this master |
| bus_oe | output | 1 | Output enable for address and attribute drivers |
| bus_addr_out | output | 32 | Address driven on the bus |
| bus_attr_out | output | 5 | Attributes driven on the bus |
| err_out | output | 1 | Misaligned burst refused (one-cycle pulse) |
| start_in | input | 1 | Start strobe observed on the bus |
| busy_in | input | 1 | Address bus busy observed on the bus |
| bus_addr_in | input | 32 | Address observed on the bus |
| bus_attr_in | input | 5 | Attributes observed on the bus |
| snp_valid | output | 1 | Snoop record updated (one-cycle pulse) |
| snp_addr | output | 32 | Captured address |
| snp_attr | output | 5 | Captured attributes |

## Verification
Every output is registered, so each result appears one cycle after the edge that samples its cause. Each result is listed below with the edge it counts from:

| Result | Due one cycle after the edge that samples |
|---|---|
| `req_ready` low | the accepted request |
| `start_out`, `bus_oe`, `busy_out` high | the grant |
| drivers released | the acknowledge |
| `err_out` pulse | the refused burst |
| `snp_valid` pulse | the qualified strobe |

The bench drives inputs and reads outputs on the falling edge. A value checked at a falling edge is therefore the reaction to the inputs set at the previous falling edge. Each check reads exactly one rising edge after the stimulus that causes it, and the pulse checks read once more one cycle later to confirm the pulse has ended.

// File: rtl/tenure_pkg.sv
package tenure_pkg;
  localparam int unsigned ADDR_W_DEF = 32;
  localparam int unsigned SIZE_W_DEF = 3;
  localparam int unsigned ATTR_W_DEF = SIZE_W_DEF + 2;

  typedef enum logic [1:0] {
    M_IDLE     = 2'd0,
    M_WAIT_GNT = 2'd1,
    M_TENURE   = 2'd2
  } mstate_e;

  function automatic logic attr_is_burst(input logic [ATTR_W_DEF-1:0] a);
    return a[ATTR_W_DEF-1];
  endfunction
endpackage

// File: rtl/tenure_align_chk.sv
module tenure_align_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ALIGN_BITS = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst,
  output logic              misaligned
);
  always_comb begin
    misaligned = burst && (|addr[ALIGN_BITS-1:0]);
  end
endmodule

// File: rtl/tenure_master.sv
module tenure_master
  import tenure_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ATTR_W     = 5,
  parameter int unsigned ALIGN_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ATTR_W-1:0] req_attr,
  input  logic              grant_in,
  input  logic              ack_in,
  output logic              start_out,
  output logic              busy_out,
  output logic              bus_oe,
  output logic [ADDR_W-1:0] bus_addr_out,
  output logic [ATTR_W-1:0] bus_attr_out,
  output logic              err_out
);
  localparam int unsigned BURST_BIT = ATTR_W - 1;

  mstate_e           state_q;
  logic              start_q, busy_q, oe_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ATTR_W-1:0] attr_q;
  logic              misaligned;
  logic              take;

  tenure_align_chk #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_align (
    .addr       (req_addr),
    .burst      (req_attr[BURST_BIT]),
    .misaligned (misaligned)
  );

  assign req_ready = (state_q == M_IDLE);
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= M_IDLE;
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      oe_q    <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      attr_q  <= '0;
    end else begin
      err_q   <= 1'b0;
      start_q <= 1'b0;
      case (state_q)
        M_IDLE: begin
          if (take) begin
            if (misaligned) begin
              err_q <= 1'b1;
            end else begin
              addr_q  <= req_addr;
              attr_q  <= req_attr;
              state_q <= M_WAIT_GNT;
            end
          end
        end
        M_WAIT_GNT: begin
          if (grant_in) begin
            start_q <= 1'b1;
            busy_q  <= 1'b1;
            oe_q    <= 1'b1;
            state_q <= M_TENURE;
          end
        end
        M_TENURE: begin
          // an acknowledge in the strobe cycle itself does not close the tenure
          if (ack_in && !start_q) begin
            busy_q  <= 1'b0;
            oe_q    <= 1'b0;
            state_q <= M_IDLE;
          end
        end
        default: state_q <= M_IDLE;
      endcase
    end
  end

  assign start_out    = start_q;
  assign busy_out     = busy_q;
  assign bus_oe       = oe_q;
  assign err_out      = err_q;
  assign bus_addr_out = oe_q ? addr_q : '0;
  assign bus_attr_out = oe_q ? attr_q : '0;
endmodule

// File: rtl/tenure_snoop.sv
module tenure_snoop #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ATTR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_in,
  input  logic              busy_in,
  input  logic              own_start,
  input  logic [ADDR_W-1:0] bus_addr_in,
  input  logic [ATTR_W-1:0] bus_attr_in,
  output logic              snp_valid,
  output logic [ADDR_W-1:0] snp_addr,
  output logic [ATTR_W-1:0] snp_attr
);
  logic capture;
  logic valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ATTR_W-1:0] attr_q;

  assign capture = start_in && busy_in && !own_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      attr_q  <= '0;
    end else begin
      valid_q <= capture;
      if (capture) begin
        addr_q <= bus_addr_in;
        attr_q <= bus_attr_in;
      end
    end
  end

  assign snp_valid = valid_q;
  assign snp_addr  = addr_q;
  assign snp_attr  = attr_q;
endmodule

// File: rtl/addr_tenure_ctrl.sv
module addr_tenure_ctrl
  import tenure_pkg::*;
#(
  parameter int unsigned ADDR_W     = ADDR_W_DEF,
  parameter int unsigned SIZE_W     = SIZE_W_DEF,
  parameter int unsigned ALIGN_BITS = 3,
  localparam int unsigned ATTR_W    = SIZE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ATTR_W-1:0] req_attr,
  input  logic              grant_in,
  input  logic              ack_in,
  output logic              start_out,
  output logic              busy_out,
  output logic              bus_oe,
  output logic [ADDR_W-1:0] bus_addr_out,
  output logic [ATTR_W-1:0] bus_attr_out,
  output logic              err_out,
  input  logic              start_in,
  input  logic              busy_in,
  input  logic [ADDR_W-1:0] bus_addr_in,
  input  logic [ATTR_W-1:0] bus_attr_in,
  output logic              snp_valid,
  output logic [ADDR_W-1:0] snp_addr,
  output logic [ATTR_W-1:0] snp_attr
);
  logic own_start;

  tenure_master #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W), .ALIGN_BITS(ALIGN_BITS)) u_master (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .req_attr     (req_attr),
    .grant_in     (grant_in),
    .ack_in       (ack_in),
    .start_out    (own_start),
    .busy_out     (busy_out),
    .bus_oe       (bus_oe),
    .bus_addr_out (bus_addr_out),
    .bus_attr_out (bus_attr_out),
    .err_out      (err_out)
  );

  tenure_snoop #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_snoop (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_in    (start_in),
    .busy_in     (busy_in),
    .own_start   (own_start),
    .bus_addr_in (bus_addr_in),
    .bus_attr_in (bus_attr_in),
    .snp_valid   (snp_valid),
    .snp_addr    (snp_addr),
    .snp_attr    (snp_attr)
  );

  assign start_out = own_start;
endmodule

// File: rtl/tenure_checks.sv
module tenure_checks #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ATTR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              grant_in,
  input logic              ack_in,
  input logic              start_out,
  input logic              busy_out,
  input logic              bus_oe,
  input logic [ADDR_W-1:0] bus_addr_out,
  input logic [ATTR_W-1:0] bus_attr_out,
  input logic              err_out,
  input logic              req_ready,
  input logic              start_in,
  input logic              busy_in,
  input logic              snp_valid
);
  a_r3_grant_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_out) |-> $past(grant_in));
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_out |=> !start_out);
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_out && !start_out) |-> ($stable(bus_addr_out) && $stable(bus_attr_out)));
  a_r5_oe_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_out |-> bus_oe);
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && busy_out && !start_out) |=> (!bus_oe && !busy_out));
  a_r7_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (start_out) |=> bus_oe);
  a_r8_no_start_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_out |-> (!start_out && req_ready));
  a_r9_snoop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snp_valid) |-> ($past(start_in) && $past(busy_in) && !$past(start_out)));
endmodule

bind addr_tenure_ctrl tenure_checks #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .grant_in     (grant_in),
  .ack_in       (ack_in),
  .start_out    (start_out),
  .busy_out     (busy_out),
  .bus_oe       (bus_oe),
  .bus_addr_out (bus_addr_out),
  .bus_attr_out (bus_attr_out),
  .err_out      (err_out),
  .req_ready    (req_ready),
  .start_in     (start_in),
  .busy_in      (busy_in),
  .snp_valid    (snp_valid)
);

// File: tb/sim_addr_tenure_ctrl.sv
`timescale 1ns/1ps
module sim_addr_tenure_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [4:0]  req_attr = '0;
  logic        grant_in = 1'b0;
  logic        ack_in = 1'b0;
  logic        start_out, busy_out, bus_oe, err_out;
  logic [31:0] bus_addr_out;
  logic [4:0]  bus_attr_out;
  logic        start_in = 1'b0;
  logic        busy_in = 1'b0;
  logic [31:0] bus_addr_in = '0;
  logic [4:0]  bus_attr_in = '0;
  logic        snp_valid;
  logic [31:0] snp_addr;
  logic [4:0]  snp_attr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addr_tenure_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_attr(req_attr), .grant_in(grant_in), .ack_in(ack_in),
    .start_out(start_out), .busy_out(busy_out), .bus_oe(bus_oe),
    .bus_addr_out(bus_addr_out), .bus_attr_out(bus_attr_out), .err_out(err_out),
    .start_in(start_in), .busy_in(busy_in), .bus_addr_in(bus_addr_in),
    .bus_attr_in(bus_attr_in), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .snp_attr(snp_attr)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [4:0]  attr;
    logic [3:0]  gnt_wait;
    logic [3:0]  ack_wait;
    logic        early_ack;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h1000_0000, 5'b00010, 4'd0, 4'd0, 1'b0},
    '{32'h2000_0008, 5'b11011, 4'd3, 4'd2, 1'b0},
    '{32'h3000_0004, 5'b10011, 4'd1, 4'd1, 1'b0},
    '{32'hDEAD_BEE1, 5'b01000, 4'd2, 4'd0, 1'b1},
    '{32'h4000_0007, 5'b11011, 4'd0, 4'd0, 1'b0},
    '{32'hFFFF_FFF8, 5'b10011, 4'd5, 4'd4, 1'b1},
    '{32'h0000_0000, 5'b00000, 4'd1, 4'd3, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_vec(input vec_t v);
    bit bad;
    bad = v.attr[4] && (v.addr[2:0] != 3'b000);
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready idle", req_ready, 1);
    req_valid = 1'b1; req_addr = v.addr; req_attr = v.attr;
    @(negedge clk);
    req_valid = 1'b0; req_addr = '0; req_attr = '0;
    if (bad) begin
      chk(err_out == 1'b1, "R8 err pulse", err_out, 1);
      chk(start_out == 1'b0 && req_ready == 1'b1, "R8 no tenure", {start_out, req_ready}, 2'b01);
      @(negedge clk);
      chk(err_out == 1'b0 && bus_oe == 1'b0, "R8 err one cycle", {err_out, bus_oe}, 0);
      return;
    end
    chk(err_out == 1'b0, "R8 no err aligned", err_out, 0);
    chk(req_ready == 1'b0, "R2 ready low pending", req_ready, 0);
    for (int i = 0; i < v.gnt_wait; i++) begin
      chk(start_out == 1'b0 && bus_oe == 1'b0, "R3 no start w/o grant", {start_out, bus_oe}, 0);
      @(negedge clk);
    end
    chk(start_out == 1'b0, "R3 no start w/o grant", start_out, 0);
    grant_in = 1'b1;
    @(negedge clk);
    grant_in = 1'b0;
    chk(start_out == 1'b1, "R3 start after grant", start_out, 1);
    chk(bus_oe && busy_out && bus_addr_out == v.addr && bus_attr_out == v.attr,
        "R5 driven in start cycle", {bus_addr_out, bus_attr_out}, {v.addr, v.attr});
    // own strobe on the bus must not be captured (R11)
    start_in = 1'b1; busy_in = 1'b1; bus_addr_in = ~v.addr; bus_attr_in = ~v.attr;
    if (v.early_ack) ack_in = 1'b1;
    @(negedge clk);
    start_in = 1'b0; busy_in = 1'b0; ack_in = 1'b0;
    chk(start_out == 1'b0, "R4 strobe one cycle", start_out, 0);
    chk(snp_valid == 1'b0, "R11 own strobe ignored", snp_valid, 0);
    chk(bus_oe == 1'b1 && busy_out == 1'b1, "R7 tenure continues", {bus_oe, busy_out}, 2'b11);
    for (int i = 0; i < v.ack_wait; i++) begin
      chk(bus_oe && busy_out && bus_addr_out == v.addr && bus_attr_out == v.attr,
          "R5 held in tenure", {bus_addr_out, bus_attr_out}, {v.addr, v.attr});
      @(negedge clk);
    end
    chk(bus_addr_out == v.addr && bus_oe, "R5 held before ack", bus_addr_out, v.addr);
    ack_in = 1'b1;
    @(negedge clk);
    ack_in = 1'b0;
    chk(bus_oe == 1'b0 && busy_out == 1'b0, "R6 release after ack", {bus_oe, busy_out}, 0);
    chk(req_ready == 1'b1, "R2 ready after ack", req_ready, 1);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({bus_oe, start_out, busy_out, snp_valid, err_out} == 5'b0 && req_ready,
        "R1 reset state", {bus_oe, start_out, busy_out, snp_valid, err_out, req_ready}, 6'b000001);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R9 qualified strobe captured
    @(negedge clk);
    start_in = 1'b1; busy_in = 1'b1; bus_addr_in = 32'hCAFE_0010; bus_attr_in = 5'b10101;
    @(negedge clk);
    start_in = 1'b0; bus_addr_in = 32'h5555_5555; bus_attr_in = 5'b01010;
    chk(snp_valid == 1'b1, "R9 snoop valid", snp_valid, 1);
    chk(snp_addr == 32'hCAFE_0010 && snp_attr == 5'b10101, "R9 snoop data",
        {snp_addr, snp_attr}, {32'hCAFE_0010, 5'b10101});
    // R10 later bus changes ignored
    @(negedge clk);
    bus_addr_in = 32'h1234_5678;
    chk(snp_valid == 1'b0, "R9 valid one cycle", snp_valid, 0);
    chk(snp_addr == 32'hCAFE_0010 && snp_attr == 5'b10101, "R10 held w/o strobe",
        snp_addr, 32'hCAFE_0010);
    @(negedge clk);
    busy_in = 1'b0;
    chk(snp_addr == 32'hCAFE_0010, "R10 held w/o strobe", snp_addr, 32'hCAFE_0010);
    // R12 strobe without busy ignored
    start_in = 1'b1; bus_addr_in = 32'h0BAD_0000;
    @(negedge clk);
    start_in = 1'b0;
    chk(snp_valid == 1'b0 && snp_addr == 32'hCAFE_0010, "R12 strobe w/o busy",
        snp_addr, 32'hCAFE_0010);
    // acknowledge outside a tenure has no effect (R6)
    ack_in = 1'b1;
    @(negedge clk);
    ack_in = 1'b0;
    chk(req_ready && !bus_oe, "R6 stray ack", {req_ready, bus_oe}, 2'b10);

    // R1 reset in mid tenure
    req_valid = 1'b1; req_addr = 32'h8000_0000; req_attr = 5'b00011;
    @(negedge clk);
    req_valid = 1'b0; grant_in = 1'b1;
    @(negedge clk);
    grant_in = 1'b0;
    held = bus_addr_out;
    chk(bus_oe && held == 32'h8000_0000, "R5 driven before reset", held, 32'h8000_0000);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk({bus_oe, start_out, busy_out, snp_valid, err_out} == 5'b0 && req_ready,
        "R1 reset mid tenure", {bus_oe, start_out, busy_out, snp_valid, err_out, req_ready}, 6'b000001);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule